// File: doc/BRIEF.md
# Two-Level Carry Lookahead Unit with 16-Bit Adder

The unit turns the group carry signals of four 4-bit adder or ALU slices into the carries those slices need, with no carry rippling from one group to the next. It takes an active-low generate and an active-low propagate from each group, plus the carry into group 0. It returns the carries into groups 1, 2 and 3. Each carry is formed as a product of sums of the group terms, which is a single inverting level of logic.

The unit also returns an active-low supergroup generate and propagate pair that describes all sixteen bits as one group. This lets the same unit be used again one level up, in a larger lookahead tree.

To exercise the unit end to end, a 16-bit adder is built around it from four 4-bit lookahead slices. Each slice forms bit generate (AND), bit propagate (OR) and a half sum equal to propagate AND NOT generate. From these it produces its four sum bits and its own active-low group pair. The adder's carry out comes from the supergroup pair and the incoming carry.

Top module: `cla16_adder`

## Requirements
- R1: Each 4-bit slice produces sum bits equal to (x + y + carry-in) mod 16, where x and y are that slice's operand nibbles; slice k covers operand bits 4k+3 down to 4k.
- R2: With G = NOT gen_n and P = NOT prop_n (bit k belongs to group k), the carry into group 1 equals G0 OR (P0 AND C0).
- R3: The carry into group 2 equals G1 OR (P1 AND G0) OR (P1 AND P0 AND C0).
- R4: The carry into group 3 equals G2 OR P2·G1 OR P2·P1·G0 OR P2·P1·P0·C0.
- R5: The supergroup generate output is low exactly when G3 OR P3·G2 OR P3·P2·G1 OR P3·P2·P1·G0 holds.
- R6: The supergroup propagate output is low exactly when all four group propagates are asserted.
- R7: The adder sum equals (a + b + cin) mod 65536 for every operand pair.
- R8: The adder carry out equals bit 16 of a + b + cin, and it is formed as supergroup G OR (supergroup P AND cin).
- R9: Adding 0xFFFF and 0x0000 with carry-in 1, or 0xFFFF and 0x0001 with carry-in 0, gives sum 0 and carry out 1. The incoming carry passes through all four groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum, modulo 2^16 |
| cout | output | 1 | Carry out of bit 15 |
| grp_gen_n | output | 1 | Active-low supergroup generate for the whole 16 bits |
| grp_prop_n | output | 1 | Active-low supergroup propagate for the whole 16 bits |

## Verification
On every evaluation, the assertions compare each product-of-sums carry and the supergroup generate against the sum-of-products recurrence. They also compare each slice's sum and group pair against its arithmetic result, and the full 17-bit result against a plain addition. Some properties hold only for the unit's inputs as the bench applies them. These are complete coverage of all 512 combinations of group generate, group propagate and carry-in (including combinations no real slice emits, such as generate without propagate), the supergroup propagate, and the corner where the carry passes through all four groups. The bench shows these by driving a standalone copy of the unit exhaustively and by driving the adder with chosen and pseudo-random operands.

// File: rtl/cla_slice4.sv
module cla_slice4 (
  input  logic [3:0] x,
  input  logic [3:0] y,
  input  logic       c0,
  output logic [3:0] s,
  output logic       gen_n,
  output logic       prop_n
);
  logic [3:0] g, p, hs;
  logic [4:0] c;

  assign g  = x & y;
  assign p  = x | y;
  assign hs = p & ~g;

  assign c[0] = c0;
  assign c[1] = g[0] | (p[0] & c0);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c0);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c0);
  assign c[4] = 1'b0;

  assign s = hs ^ c[3:0];

  assign gen_n  = ~(g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]));
  assign prop_n = ~(&p);

  always_comb begin
    // R1
    slice_sum_chk: assert ({(~gen_n | (~prop_n & c0)), s} == ({1'b0, x} + {1'b0, y} + {4'd0, c0}))
      else $error("slice sum mismatch");
  end
endmodule

// File: rtl/lookahead_carry_unit.sv
module lookahead_carry_unit (
  input  logic [3:0] gen_n,
  input  logic [3:0] prop_n,
  input  logic       c0,
  output logic       c1,
  output logic       c2,
  output logic       c3,
  output logic       sgen_n,
  output logic       sprop_n
);
  logic [3:0] gg, pp;

  assign gg = ~gen_n;
  assign pp = ~prop_n;

  assign c1 = (gg[0] | pp[0]) & (gg[0] | c0);
  assign c2 = (gg[1] | pp[1]) & (gg[1] | gg[0] | pp[0]) & (gg[1] | gg[0] | c0);
  assign c3 = (gg[2] | pp[2]) & (gg[2] | gg[1] | pp[1]) & (gg[2] | gg[1] | gg[0] | pp[0])
            & (gg[2] | gg[1] | gg[0] | c0);

  assign sgen_n  = ~((gg[3] | pp[3]) & (gg[3] | gg[2] | pp[2]) & (gg[3] | gg[2] | gg[1] | pp[1])
                   & (gg[3] | gg[2] | gg[1] | gg[0]));
  assign sprop_n = ~(pp[0] & pp[1] & pp[2] & pp[3]);

  always_comb begin
    // R2
    c1_sop_chk: assert (c1 == (gg[0] | (pp[0] & c0))) else $error("c1 mismatch");
    // R3
    c2_sop_chk: assert (c2 == (gg[1] | (pp[1] & c1))) else $error("c2 mismatch");
    // R4
    c3_sop_chk: assert (c3 == (gg[2] | (pp[2] & c2))) else $error("c3 mismatch");
    // R5
    sgen_sop_chk: assert (sgen_n == ~(gg[3] | (pp[3] & (gg[2] | (pp[2] & (gg[1] | (pp[1] & gg[0])))))))
      else $error("supergroup generate mismatch");
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int GROUPS = 4
) (
  input  logic [15:0] a,
  input  logic [15:0] b,
  input  logic        cin,
  output logic [15:0] sum,
  output logic        cout,
  output logic        grp_gen_n,
  output logic        grp_prop_n
);
  localparam int NIB = 4;
  logic [GROUPS-1:0] gn, pn, cg;

  assign cg[0] = cin;

  for (genvar k = 0; k < GROUPS; k++) begin : g_slice
    cla_slice4 u_slice (
      .x      (a[NIB*k +: NIB]),
      .y      (b[NIB*k +: NIB]),
      .c0     (cg[k]),
      .s      (sum[NIB*k +: NIB]),
      .gen_n  (gn[k]),
      .prop_n (pn[k])
    );
  end

  lookahead_carry_unit u_lcu (
    .gen_n   (gn),
    .prop_n  (pn),
    .c0      (cin),
    .c1      (cg[1]),
    .c2      (cg[2]),
    .c3      (cg[3]),
    .sgen_n  (grp_gen_n),
    .sprop_n (grp_prop_n)
  );

  assign cout = ~grp_gen_n | (~grp_prop_n & cin);

  always_comb begin
    // R7
    sum_add_chk: assert (sum == 16'(a + b + 16'(cin))) else $error("sum mismatch");
    // R8
    cout_add_chk: assert (cout == ((17'(a) + 17'(b) + 17'(cin)) >> 16)) else $error("carry out mismatch");
  end
endmodule

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [15:0] a, b;
  logic        cin;
  logic [15:0] sum;
  logic        cout, ggn, gpn;

  logic [3:0] ugn, upn;
  logic       uc0, uc1, uc2, uc3, usg, usp;

  cla16_adder uut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
                   .grp_gen_n(ggn), .grp_prop_n(gpn));

  lookahead_carry_unit lcu_uut (.gen_n(ugn), .prop_n(upn), .c0(uc0), .c1(uc1), .c2(uc2),
                                .c3(uc3), .sgen_n(usg), .sprop_n(usp));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_add(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    logic [16:0] tot;
    logic [3:0] eg, ep;
    logic [4:0] n;
    logic sg, sp;
    a = va; b = vb; cin = vc;
    #(PERIOD/2);
    tot = 17'(va) + 17'(vb) + 17'(vc);
    for (int k = 0; k < 4; k++) begin
      n = 5'(va[4*k +: 4]) + 5'(vb[4*k +: 4]);
      eg[k] = n[4];
      ep[k] = &(va[4*k +: 4] | vb[4*k +: 4]);
    end
    sg = eg[3] | (ep[3] & eg[2]) | (ep[3] & ep[2] & eg[1]) | (ep[3] & ep[2] & ep[1] & eg[0]);
    sp = &ep;
    n = 5'(va[3:0]) + 5'(vb[3:0]) + 5'(vc);
    check(sum[3:0] == n[3:0], "R1 low slice sum", int'(sum[3:0]), int'(n[3:0]));
    check(sum == tot[15:0], "R7 sum", int'(sum), int'(tot[15:0]));
    check(cout == tot[16], "R8 cout", int'(cout), int'(tot[16]));
    check(ggn == ~sg, "R5 adder supergroup generate", int'(ggn), int'(~sg));
    check(gpn == ~sp, "R6 adder supergroup propagate", int'(gpn), int'(~sp));
    #(PERIOD/2);
  endtask

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, rb;
    a = '0; b = '0; cin = 1'b0;
    ugn = '1; upn = '1; uc0 = 1'b0;
    @(negedge clk);
    // reset-like idle state: zero operands give zero result and inactive generate
    check(sum == 16'd0 && cout == 1'b0, "R7 idle zero", int'(sum), 0);
    check(ggn == 1'b1, "R5 idle generate", int'(ggn), 1);

    for (int v = 0; v < 512; v++) begin
      logic [3:0] g, p;
      logic c, e1, e2, e3, s;
      ugn = v[3:0]; upn = v[7:4]; uc0 = v[8];
      #(PERIOD/2);
      g = ~ugn; p = ~upn; c = uc0;
      c = g[0] | (p[0] & c); e1 = c;
      c = g[1] | (p[1] & c); e2 = c;
      c = g[2] | (p[2] & c); e3 = c;
      s = 1'b0;
      for (int i = 0; i < 4; i++) s = g[i] | (p[i] & s);
      check(uc1 == e1, "R2 c1", int'(uc1), int'(e1));
      check(uc2 == e2, "R3 c2", int'(uc2), int'(e2));
      check(uc3 == e3, "R4 c3", int'(uc3), int'(e3));
      check(usg == ~s, "R5 sgen_n", int'(usg), int'(~s));
      check(usp == ~(&p), "R6 sprop_n", int'(usp), int'(~(&p)));
      #(PERIOD/2);
    end

    // R9 carry through all four groups
    run_add(16'hFFFF, 16'h0001, 1'b0);
    check(sum == 16'h0000 && cout == 1'b1, "R9 ones plus one", int'({cout, sum}), 32'h10000);
    run_add(16'hFFFF, 16'h0000, 1'b1);
    check(sum == 16'h0000 && cout == 1'b1, "R9 ones plus carry-in", int'({cout, sum}), 32'h10000);
    run_add(16'hFFFF, 16'hFFFF, 1'b1);
    run_add(16'h0F0F, 16'h00F1, 1'b0);
    run_add(16'h8000, 16'h8000, 1'b0);
    run_add(16'h7FFF, 16'h0000, 1'b1);

    ra = 16'hACE1; rb = 16'h1357;
    for (int i = 0; i < 2000; i++) begin
      ra = {ra[14:0], ra[15] ^ ra[13] ^ ra[12] ^ ra[10]};
      rb = rb * 16'd25173 + 16'd13849;
      run_add(ra, rb, ra[0] ^ rb[3]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule